// File: doc/BRIEF.md
# Eight-Pin Port with Configurable Pin Interrupt Detection

This block is a small general-purpose I/O port of up to eight pins. Every pin input is brought into the clock domain through two flip-flops. Each pin then feeds its own detector. Software picks, per pin, whether the detector watches a level or an edge. For edges it chooses one edge or both. The polarity bit selects which level or which single edge counts.

A raw status word shows which pins are asserting. A bit caused by an edge stays set until software writes a one to that bit of the clear register. A bit caused by a level simply follows the pin. The raw status is ANDed with a per-pin enable to form the masked status, and one interrupt line is the OR of the masked bits.

The port also holds basic pad-control registers:
- output data and direction, which drive the pads
- alternate-function select, pull-up enable and digital enable

The last three come out of reset with chosen pins already set, so that a debug function owns those pins from power-up. A parameter marks which pins exist. Register bits for pins that do not exist take no writes and read as zero.

Top module: `gpio_pin_irq`

## Requirements
- R1: A pin change reaches the detection logic only after two clock edges of synchronization. A level interrupt on an enabled pin appears on `irq` after the second rising clock edge that follows the pin change, and not after the first.
- R2: The sense register selects the detection kind for each pin. A bit value of 0 selects edge detection and 1 selects level detection. A level-sensed raw status bit follows the synchronized pin and is never latched.
- R3: The polarity register selects which condition counts. A bit value of 0 means low level or falling edge, and 1 means high level or rising edge. In single-edge mode the opposite edge leaves the raw bit unchanged.
- R4: In the both-edges register, a bit value of 1 makes both rising and falling edges set the raw bit, and the polarity bit is then ignored. For a level-sensed pin the both-edges bit has no effect.
- R5: The masked status is raw status AND the enable register, where enable 1 passes a pin. `irq` is high exactly when some masked status bit is 1, so an enable of 0 keeps `irq` low.
- R6: An edge-set raw bit stays set until a 1 is written to the same bit of the clear register (address 8). Writing 0 bits there changes nothing, and reading address 8 returns 0.
- R7: Pins whose bit in PIN_MASK is 0 ignore writes in every register, read as 0, and never set raw status or `irq`.
- R8: After reset the alternate-select (address 9), pull-up (address 10) and digital-enable (address 11) registers hold DEBUG_RST for the implemented pins. Every other register holds 0 after reset.
- R9: A read with `reg_rd` high returns data on `reg_rdata` after the next rising edge, and `reg_rdata` holds its value while no read is made. The address map is:
  - 0: data
  - 1: direction
  - 2: sense
  - 3: both-edges
  - 4: polarity
  - 5: enable
  - 6: raw status (read only)
  - 7: masked status (read only)
  - 8: clear
  - 9 to 11: as given in R8
  - any other address: reads 0
- R10: `pad_oe` equals the direction register, where 1 means output, and `pad_out` equals the data register. A read of address 0 returns the written data for output pins and the synchronized pin value for input pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_in | input | NPINS | Asynchronous pin levels |
| pad_out | output | NPINS | Output data to pads |
| pad_oe | output | NPINS | Output enable per pad (1 = drive) |
| alt_sel | output | NPINS | Alternate-function select per pad |
| pull_en | output | NPINS | Pull-up enable per pad |
| dig_en | output | NPINS | Digital enable per pad |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | NPINS | Write data |
| reg_rdata | output | NPINS | Read data, one cycle after the strobe |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets the places where the modes interact:
- A rising edge on a falling-edge pin must leave its raw bit clear. A design with the polarity test inverted would flag the wrong edge.
- A level-sensed pin that also has both-edges set must drop its raw bit when the pin returns. A design that let the both-edges bit reach level mode would leave that bit stuck.
- A clear write of zero bits must leave a latched bit alone. A design that cleared on any write would lose the event.
- The missing pin must stay silent even when all its control bits are written with ones.
- The interrupt must not appear one cycle early. A design that dropped a synchronizer stage would show it one cycle too soon.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_DATA   = 4'd0,
        RA_DIR    = 4'd1,
        RA_SENSE  = 4'd2,
        RA_BOTH   = 4'd3,
        RA_POL    = 4'd4,
        RA_ENABLE = 4'd5,
        RA_RAW    = 4'd6,
        RA_MSKD   = 4'd7,
        RA_CLEAR  = 4'd8,
        RA_ALT    = 4'd9,
        RA_PULL   = 4'd10,
        RA_DEN    = 4'd11
    } reg_addr_e;

    // per-pin detection mode
    typedef struct packed {
        logic level;   // 1: level sensed, 0: edge sensed
        logic both;    // 1: both edges (edge mode only)
        logic high;    // 1: high level / rising edge
    } pin_mode_t;

    function automatic logic edge_hit(pin_mode_t m, logic cur, logic prv);
        logic rise;
        logic fall;
        rise = cur & ~prv;
        fall = ~cur & prv;
        if (m.both)
            return rise | fall;
        return m.high ? rise : fall;
    endfunction

    function automatic logic level_hit(pin_mode_t m, logic cur);
        return cur == m.high;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

    // R1: second stage always carries the first stage of the previous cycle
    assert_two_stage_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> q == $past(stage1));
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
    import gpio_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pin_mode_t mode,
    input  logic      cur,
    input  logic      clr,
    output logic      raw
);
    logic prev;
    logic held;
    logic hit;

    assign hit = edge_hit(mode, cur, prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b0;
            held <= 1'b0;
        end else begin
            prev <= cur;
            held <= (held & ~clr) | hit;
        end
    end

    assign raw = mode.level ? level_hit(mode, cur) : held;

    // R6: a latched event survives until cleared
    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (held && !clr) |=> held);

    // R6: a clear with no fresh edge empties the latch
    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit) |=> !held);

    // R4: any edge event needs the sampled pin to have changed
    assert_edge_change_R4: assert property (@(posedge clk) disable iff (rst)
        hit |-> (cur != prev));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_irq_pkg::*;
#(
    parameter int           W        = 8,
    parameter logic [W-1:0] IMPL     = '1,
    parameter logic [W-1:0] DBG_RST  = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    input  logic [W-1:0]      raw_st,
    input  logic [W-1:0]      msk_st,
    input  logic [W-1:0]      din,
    output logic [W-1:0]      sense,
    output logic [W-1:0]      both,
    output logic [W-1:0]      pol,
    output logic [W-1:0]      enable,
    output logic [W-1:0]      dir,
    output logic [W-1:0]      dout,
    output logic [W-1:0]      alt,
    output logic [W-1:0]      pull,
    output logic [W-1:0]      den,
    output logic [W-1:0]      clr
);
    localparam logic [W-1:0] PAD_RST = DBG_RST & IMPL;

    reg_addr_e    a;
    logic [W-1:0] wv;
    logic [W-1:0] rd_val;

    assign a   = reg_addr_e'(addr);
    assign wv  = wdata & IMPL;
    assign clr = (wr && a == RA_CLEAR) ? wv : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sense  <= '0;
            both   <= '0;
            pol    <= '0;
            enable <= '0;
            dir    <= '0;
            dout   <= '0;
            alt    <= PAD_RST;
            pull   <= PAD_RST;
            den    <= PAD_RST;
        end else if (wr) begin
            case (a)
                RA_DATA:   dout   <= wv;
                RA_DIR:    dir    <= wv;
                RA_SENSE:  sense  <= wv;
                RA_BOTH:   both   <= wv;
                RA_POL:    pol    <= wv;
                RA_ENABLE: enable <= wv;
                RA_ALT:    alt    <= wv;
                RA_PULL:   pull   <= wv;
                RA_DEN:    den    <= wv;
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (a)
            RA_DATA:   rd_val = (dir & dout) | (~dir & din);
            RA_DIR:    rd_val = dir;
            RA_SENSE:  rd_val = sense;
            RA_BOTH:   rd_val = both;
            RA_POL:    rd_val = pol;
            RA_ENABLE: rd_val = enable;
            RA_RAW:    rd_val = raw_st;
            RA_MSKD:   rd_val = msk_st;
            RA_ALT:    rd_val = alt;
            RA_PULL:   rd_val = pull;
            RA_DEN:    rd_val = den;
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd)
            rdata <= rd_val & IMPL;
    end

    // R9: read data holds while no read is issued
    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata));

    // R7: bits of missing pins never read as 1
    assert_unimpl_read_R7: assert property (@(posedge clk) disable iff (rst)
        (rdata & ~IMPL) == '0);
endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq
    import gpio_irq_pkg::*;
#(
    parameter int                NPINS     = 8,
    parameter logic [NPINS-1:0]  PIN_MASK  = '1,
    parameter logic [NPINS-1:0]  DEBUG_RST = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  alt_sel,
    output logic [NPINS-1:0]  pull_en,
    output logic [NPINS-1:0]  dig_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    output logic              irq
);
    logic [NPINS-1:0] pin_s;
    logic [NPINS-1:0] raw_st;
    logic [NPINS-1:0] msk_st;
    logic [NPINS-1:0] sense, both, pol, enable, clr;

    gpio_sync #(.W(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_s)
    );

    gpio_regs #(.W(NPINS), .IMPL(PIN_MASK), .DBG_RST(DEBUG_RST)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (reg_addr),
        .wr     (reg_wr),
        .rd     (reg_rd),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .raw_st (raw_st),
        .msk_st (msk_st),
        .din    (pin_s),
        .sense  (sense),
        .both   (both),
        .pol    (pol),
        .enable (enable),
        .dir    (pad_oe),
        .dout   (pad_out),
        .alt    (alt_sel),
        .pull   (pull_en),
        .den    (dig_en),
        .clr    (clr)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        if (PIN_MASK[i]) begin : g_on
            pin_mode_t m;
            assign m = '{level: sense[i], both: both[i], high: pol[i]};
            gpio_pin_detect u_det (
                .clk  (clk),
                .rst  (rst),
                .mode (m),
                .cur  (pin_s[i]),
                .clr  (clr[i]),
                .raw  (raw_st[i])
            );
        end else begin : g_off
            assign raw_st[i] = 1'b0;
        end
    end

    assign msk_st = raw_st & enable;
    assign irq    = |msk_st;

    // R5: with every pin disabled the line stays low
    assert_mask_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (enable == '0) |-> !irq);

    // R7: missing pins never raise raw status
    assert_unimpl_raw_R7: assert property (@(posedge clk) disable iff (rst)
        (raw_st & ~PIN_MASK) == '0);
endmodule

// File: tb/sim_gpio_pin_irq.sv
module sim_gpio_pin_irq;
    localparam logic [7:0] IMPL = 8'h7F;
    localparam logic [7:0] DBG  = 8'h8F;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pad_in = '0;
    logic [3:0] addr = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] pad_out, pad_oe, alt_sel, pull_en, dig_en, rdata;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    gpio_pin_irq #(.NPINS(8), .PIN_MASK(IMPL), .DEBUG_RST(DBG)) u0 (
        .clk(clk), .rst(rst), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .alt_sel(alt_sel), .pull_en(pull_en), .dig_en(dig_en),
        .reg_addr(addr), .reg_wr(wr), .reg_rd(rd), .reg_wdata(wdata),
        .reg_rdata(rdata), .irq(irq)
    );

    // behavioural reference model
    logic [7:0] m_s1, m_s, m_prev, m_lat;
    logic [7:0] m_sense, m_both, m_pol, m_en, m_dir, m_dout, m_alt, m_pull, m_den, m_rdata;

    function automatic logic [7:0] m_raw();
        return ((m_sense & ~(m_s ^ m_pol)) | (~m_sense & m_lat)) & IMPL;
    endfunction

    function automatic logic [7:0] m_read(input logic [3:0] a);
        case (a)
            4'd0:  return ((m_dir & m_dout) | (~m_dir & m_s)) & IMPL;
            4'd1:  return m_dir;
            4'd2:  return m_sense;
            4'd3:  return m_both;
            4'd4:  return m_pol;
            4'd5:  return m_en;
            4'd6:  return m_raw();
            4'd7:  return m_raw() & m_en;
            4'd9:  return m_alt;
            4'd10: return m_pull;
            4'd11: return m_den;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [7:0] rise, fall, trig, clrv, wv;
        if (rst) begin
            m_s1 = 0; m_s = 0; m_prev = 0; m_lat = 0;
            m_sense = 0; m_both = 0; m_pol = 0; m_en = 0; m_dir = 0; m_dout = 0;
            m_alt = DBG & IMPL; m_pull = DBG & IMPL; m_den = DBG & IMPL; m_rdata = 0;
        end else begin
            rise = m_s & ~m_prev;
            fall = ~m_s & m_prev;
            trig = ((m_both & (rise | fall)) | (~m_both & ((m_pol & rise) | (~m_pol & fall)))) & IMPL;
            wv   = wdata & IMPL;
            clrv = (wr && addr == 4'd8) ? wv : 8'h00;
            if (rd) m_rdata = m_read(addr);
            m_lat = (m_lat & ~clrv) | trig;
            if (wr) begin
                case (addr)
                    4'd0:  m_dout  = wv;
                    4'd1:  m_dir   = wv;
                    4'd2:  m_sense = wv;
                    4'd3:  m_both  = wv;
                    4'd4:  m_pol   = wv;
                    4'd5:  m_en    = wv;
                    4'd9:  m_alt   = wv;
                    4'd10: m_pull  = wv;
                    4'd11: m_den   = wv;
                    default: ;
                endcase
            end
            m_prev = m_s;
            m_s    = m_s1;
            m_s1   = pad_in;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R5 irq", {7'b0, irq}, {7'b0, |(m_raw() & m_en)});
            chk("R9 rdata", rdata, m_rdata);
            chk("R10 pad_oe", pad_oe, m_dir);
            chk("R10 pad_out", pad_out, m_dout);
            chk("R8 alt_sel", alt_sel, m_alt);
        end
    end

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0; v = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clean_cfg();
        wr_reg(4'd5, 8'h00);
        wr_reg(4'd2, 8'h00);
        wr_reg(4'd3, 8'h00);
        wr_reg(4'd4, 8'h00);
        wr_reg(4'd8, 8'hFF);
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R8 reset values
        rd_reg(4'd9, v);  chk("R8 alt reset", v, 8'h0F);
        rd_reg(4'd10, v); chk("R8 pull reset", v, 8'h0F);
        rd_reg(4'd11, v); chk("R8 den reset", v, 8'h0F);
        rd_reg(4'd5, v);  chk("R8 enable reset", v, 8'h00);
        chk("R8 irq reset", {7'b0, irq}, 8'h00);

        // R1/R2 high level on pin 0
        wr_reg(4'd2, 8'h01); wr_reg(4'd4, 8'h01); wr_reg(4'd5, 8'h01);
        pad_in[0] = 1'b1;
        @(negedge clk); chk("R1 one stage not enough", {7'b0, irq}, 8'h00);
        @(negedge clk); chk("R1 level after two stages", {7'b0, irq}, 8'h01);
        rd_reg(4'd6, v); chk("R2 raw level", v, 8'h01);
        pad_in[0] = 1'b0; idle(3);
        chk("R2 level not latched irq", {7'b0, irq}, 8'h00);
        rd_reg(4'd6, v); chk("R2 level not latched raw", v, 8'h00);
        clean_cfg();

        // R3 low level on pin 1, R5 masking
        wr_reg(4'd2, 8'h02);
        rd_reg(4'd6, v); chk("R3 low level raw", v, 8'h02);
        rd_reg(4'd7, v); chk("R5 masked when disabled", v, 8'h00);
        chk("R5 irq off when disabled", {7'b0, irq}, 8'h00);
        wr_reg(4'd5, 8'h02);
        chk("R5 irq on when enabled", {7'b0, irq}, 8'h01);
        pad_in[1] = 1'b1; idle(3);
        chk("R3 high pin clears low level", {7'b0, irq}, 8'h00);
        pad_in[1] = 1'b0; idle(3);
        clean_cfg();

        // R3/R6 rising edge on pin 2
        wr_reg(4'd4, 8'h04); wr_reg(4'd5, 8'h04);
        pad_in[2] = 1'b1; idle(3);
        rd_reg(4'd6, v); chk("R3 rising edge raw", v, 8'h04);
        chk("R6 irq on edge", {7'b0, irq}, 8'h01);
        pad_in[2] = 1'b0; idle(3);
        rd_reg(4'd6, v); chk("R6 edge stays latched", v, 8'h04);
        wr_reg(4'd8, 8'h00);
        rd_reg(4'd6, v); chk("R6 zero clear no effect", v, 8'h04);
        wr_reg(4'd8, 8'h04);
        chk("R6 clear drops irq", {7'b0, irq}, 8'h00);
        rd_reg(4'd6, v); chk("R6 raw cleared", v, 8'h00);
        rd_reg(4'd8, v); chk("R6 clear reads zero", v, 8'h00);
        clean_cfg();

        // R3 falling edge on pin 3
        wr_reg(4'd5, 8'h08);
        pad_in[3] = 1'b1; idle(3);
        rd_reg(4'd6, v); chk("R3 rising ignored in falling mode", v, 8'h00);
        pad_in[3] = 1'b0; idle(3);
        rd_reg(4'd6, v); chk("R3 falling edge raw", v, 8'h08);
        clean_cfg();

        // R4 both edges on pin 4, polarity ignored
        wr_reg(4'd3, 8'h10); wr_reg(4'd4, 8'h10); wr_reg(4'd5, 8'h10);
        pad_in[4] = 1'b1; idle(3);
        rd_reg(4'd6, v); chk("R4 both rising", v, 8'h10);
        wr_reg(4'd8, 8'h10);
        pad_in[4] = 1'b0; idle(3);
        rd_reg(4'd6, v); chk("R4 both falling", v, 8'h10);
        clean_cfg();

        // R4 both-edges has no effect in level mode, pin 5
        wr_reg(4'd2, 8'h20); wr_reg(4'd3, 8'h20); wr_reg(4'd4, 8'h20);
        rd_reg(4'd6, v); chk("R4 level low idle", v, 8'h00);
        pad_in[5] = 1'b1; idle(3);
        rd_reg(4'd6, v); chk("R4 level high", v, 8'h20);
        pad_in[5] = 1'b0; idle(3);
        rd_reg(4'd6, v); chk("R4 level ignores both", v, 8'h00);
        clean_cfg();

        // R7 missing pin 7
        wr_reg(4'd2, 8'hFF);
        rd_reg(4'd2, v); chk("R7 sense write masked", v, 8'h7F);
        wr_reg(4'd2, 8'h00); wr_reg(4'd4, 8'h80); wr_reg(4'd5, 8'hFF);
        rd_reg(4'd5, v); chk("R7 enable write masked", v, 8'h7F);
        pad_in[7] = 1'b1; idle(3);
        rd_reg(4'd6, v); chk("R7 no raw on missing pin", v, 8'h00);
        chk("R7 no irq on missing pin", {7'b0, irq}, 8'h00);
        pad_in[7] = 1'b0; idle(3);
        clean_cfg();

        // R9 unmapped address
        rd_reg(4'd15, v); chk("R9 unmapped reads zero", v, 8'h00);

        // R10 direction and data
        wr_reg(4'd1, 8'h0F); wr_reg(4'd0, 8'hA5);
        chk("R10 pad_oe", pad_oe, 8'h0F);
        chk("R10 pad_out", pad_out, 8'h25);
        pad_in = 8'h50; idle(3);
        rd_reg(4'd0, v); chk("R10 data readback", v, 8'h55);
        pad_in = 8'h00; idle(4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule